// File: doc/BRIEF.md
# Carry-Precomputed Unsigned Multiplier Element

This block multiplies two unsigned operands of `W` bits (4 by default) and returns the full `2W`-bit product without a clock. It works in three stages. First, an AND array forms every single-bit partial product. Second, a carry network sizes each product column and derives its outgoing carries by selection. Third, an XOR stage forms each product bit from the partial products of its column and the carries that enter that column.

In the carry network, each column first counts its own partial products together with the weight-two carry that comes from two columns below. Two candidate results are then prepared: one for an incoming weight-one carry of 0 and one for an incoming weight-one carry of 1. The real carry from the column below picks between them. Each column therefore emits a weight-one carry and a weight-two carry. No chain of full adders is needed to do this.

The block is meant to be tiled into wider multipliers. Each tile computes one sub-product of the split operands.

Top module: `cpc_mul4`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `a_op * b_op`. With the default `W = 4`, all 256 pairs give the exact 8-bit product.
- R2: Product bit 0 equals `a_op[0] & b_op[0]`.
- R3: If either operand is zero, the whole product is zero.
- R4: Multiplying by one returns the other operand, zero-extended.
- R5: With both operands all ones, the product is (2^W-1)^2. With `W = 4` this is 225 (0xE1).
- R6: Multiplying by 2^j (only bit j set) gives the other operand shifted left by j places. This exercises each column's carry path.
- R7: The block holds no state. A change on the operands shows up on `prod` within the same clock period, and the previous operands have no effect.
- R8: No carry leaves the top column. The product never exceeds (2^W-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | W (4) | Unsigned multiplicand |
| b_op | input | W (4) | Unsigned multiplier |
| prod | output | 2W (8) | Unsigned product |

## Verification
Every result is due in the same cycle as its stimulus, because there is no register between the operands and `prod`. The bench applies operands just after a rising edge of its pacing clock. It samples `prod` on the following falling edge, half a period later, so each reading belongs to exactly one operand pair. For R7, operands are changed back to back on successive edges, and each sample is compared only with the pair that was applied in that period. This shows that an earlier pair leaves no trace.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  // Default operand width. The carry network supports 2..5, so that the
  // column count fits the three weights (1, 2, 4) it resolves.
  localparam int unsigned CPC_W_DEF = 4;

  // Width of a column population count for operand width w.
  function automatic int unsigned cpc_cnt_w(input int unsigned w);
    return $clog2(w + 3);
  endfunction

endpackage

// File: rtl/cpc_pp_gen.sv
module cpc_pp_gen #(
  parameter int unsigned W = cpc_pkg::CPC_W_DEF
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [W*W-1:0] pp_bits
);

  // pp_bits[j*W + i] = mcand[i] & mplier[j]; its column is i + j.
  for (genvar j = 0; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_col
      assign pp_bits[j*W + i] = mcand[i] & mplier[j];
    end
  end

  // R3: a zero multiplicand empties the whole array
  always_comb begin
    p_zero_rows_r3: assert (mcand != '0 || pp_bits == '0)
      else $error("partial products present with zero multiplicand");
  end

endmodule

// File: rtl/cpc_carry_net.sv
module cpc_carry_net #(
  parameter int unsigned W = cpc_pkg::CPC_W_DEF
) (
  input  logic [W*W-1:0] pp_bits,
  output logic [2*W-2:0] cy_one,   // carry of column k into column k+1
  output logic [2*W-2:0] cy_two    // carry of column k into column k+2
);

  localparam int unsigned NCOL = 2*W - 1;
  localparam int unsigned CW   = cpc_pkg::cpc_cnt_w(W);

  logic [CW-1:0] base_cnt [NCOL];
  logic [CW-1:0] cand_lo  [NCOL];
  logic [CW-1:0] cand_hi  [NCOL];
  logic [CW-1:0] picked   [NCOL];

  // Local count: the column's own partial products plus the weight-two
  // carry from two columns down. Both candidates are formed before the
  // weight-one carry from the column below arrives; that carry only selects.
  always_comb begin
    cy_one = '0;
    cy_two = '0;
    for (int k = 0; k < int'(NCOL); k++) begin
      base_cnt[k] = '0;
      for (int i = 0; i < int'(W); i++) begin
        if (k - i >= 0 && k - i < int'(W)) begin
          base_cnt[k] = base_cnt[k] + CW'(pp_bits[(k-i)*int'(W) + i]);
        end
      end
      if (k >= 2) begin
        base_cnt[k] = base_cnt[k] + CW'(cy_two[k-2]);
      end
      cand_lo[k] = base_cnt[k];
      cand_hi[k] = base_cnt[k] + CW'(1);
      if (k >= 1) begin
        picked[k] = cy_one[k-1] ? cand_hi[k] : cand_lo[k];
      end else begin
        picked[k] = cand_lo[k];
      end
      cy_one[k] = picked[k][1];
      cy_two[k] = picked[k][2];
    end
  end

  // R6: the two lowest columns hold at most three units, so they never
  // produce a weight-two carry
  always_comb begin
    p_low_cols_r6: assert (cy_two[0] == 1'b0 && cy_two[1] == 1'b0)
      else $error("weight-two carry from a low column");
  end

  // R2: column 0 holds a single partial product and never carries
  always_comb begin
    p_col0_quiet_r2: assert (cy_one[0] == 1'b0)
      else $error("carry out of column 0");
  end

endmodule

// File: rtl/cpc_xor_sum.sv
module cpc_xor_sum #(
  parameter int unsigned W = cpc_pkg::CPC_W_DEF
) (
  input  logic [W*W-1:0] pp_bits,
  input  logic [2*W-2:0] cy_one,
  input  logic [2*W-2:0] cy_two,
  output logic [2*W-1:0] prod_bits
);

  localparam int unsigned NCOL = 2*W - 1;

  always_comb begin
    prod_bits = '0;
    for (int k = 0; k < int'(NCOL); k++) begin
      for (int i = 0; i < int'(W); i++) begin
        if (k - i >= 0 && k - i < int'(W)) begin
          prod_bits[k] = prod_bits[k] ^ pp_bits[(k-i)*int'(W) + i];
        end
      end
      if (k >= 1) prod_bits[k] = prod_bits[k] ^ cy_one[k-1];
      if (k >= 2) prod_bits[k] = prod_bits[k] ^ cy_two[k-2];
    end
    prod_bits[2*W-1] = cy_one[NCOL-1] ^ cy_two[NCOL-2];
  end

  // R8: nothing may spill past the top product bit
  always_comb begin
    p_no_overflow_r8: assert (cy_two[NCOL-1] == 1'b0 &&
                              !(cy_one[NCOL-1] && cy_two[NCOL-2]))
      else $error("carry leaves the top column");
  end

endmodule

// File: rtl/cpc_mul4.sv
module cpc_mul4 #(
  parameter int unsigned W = cpc_pkg::CPC_W_DEF
) (
  input  logic [W-1:0]   a_op,
  input  logic [W-1:0]   b_op,
  output logic [2*W-1:0] prod
);

  localparam int unsigned NPP = W * W;
  localparam int unsigned PW  = 2 * W;

  logic [NPP-1:0]  pp_bits;
  logic [PW-2:0]   cy_one;
  logic [PW-2:0]   cy_two;

  cpc_pp_gen #(.W(W)) u_pp_gen (
    .mcand   (a_op),
    .mplier  (b_op),
    .pp_bits (pp_bits)
  );

  cpc_carry_net #(.W(W)) u_carry_net (
    .pp_bits (pp_bits),
    .cy_one  (cy_one),
    .cy_two  (cy_two)
  );

  cpc_xor_sum #(.W(W)) u_xor_sum (
    .pp_bits   (pp_bits),
    .cy_one    (cy_one),
    .cy_two    (cy_two),
    .prod_bits (prod)
  );

  // R1: the assembled product matches the arithmetic product
  always_comb begin
    p_exact_product_r1: assert (prod == PW'(a_op) * PW'(b_op))
      else $error("product mismatch");
  end

  // R2: lowest product bit is the lone column-0 term
  always_comb begin
    p_lsb_r2: assert (prod[0] == (a_op[0] & b_op[0]))
      else $error("product bit 0 wrong");
  end

endmodule

// File: tb/cpc_mul4_bench.sv
module cpc_mul4_bench;

  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  a_op;
  logic [W-1:0]  b_op;
  logic [PW-1:0] prod;

  int n_checks;
  int n_errors;
  bit done;

  cpc_mul4 #(.W(W)) u_cpc_mul4 (
    .a_op (a_op),
    .b_op (b_op),
    .prod (prod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [PW-1:0] ref_prod(input int a, input int b);
    return PW'(a * b);
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] got,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // apply after a rising edge, sample at the next falling edge
  task automatic apply(input int a, input int b);
    @(posedge clk);
    #0.5;
    a_op = W'(a);
    b_op = W'(b);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a_op     = '0;
    b_op     = '0;
    seed     = 32'd1234;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // reset state: zero operands give zero (R3)
    @(negedge clk);
    check("R3 idle", prod, '0);

    // R1 / R2 / R8: exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        apply(a, b);
        check("R1 exhaustive", prod, ref_prod(a, b));
        check("R2 lsb", PW'(prod[0]), PW'((a & b) & 1));
        if (prod > PW'(((1 << W) - 1) * ((1 << W) - 1)))
          check("R8 bound", prod, PW'(((1 << W) - 1) * ((1 << W) - 1)));
      end
    end

    // R3: zero on either side
    for (int v = 0; v < (1 << W); v++) begin
      apply(0, v);
      check("R3 a zero", prod, '0);
      apply(v, 0);
      check("R3 b zero", prod, '0);
    end

    // R4: identity
    for (int v = 0; v < (1 << W); v++) begin
      apply(v, 1);
      check("R4 b one", prod, PW'(v));
      apply(1, v);
      check("R4 a one", prod, PW'(v));
    end

    // R5: all ones
    apply((1 << W) - 1, (1 << W) - 1);
    check("R5 max", prod, 8'hE1);

    // R6: powers of two
    for (int j = 0; j < W; j++) begin
      for (int v = 0; v < (1 << W); v++) begin
        apply(v, 1 << j);
        check("R6 shift", prod, PW'(v) << j);
      end
    end

    // R7: back-to-back random pairs, each sampled in its own period
    for (int n = 0; n < 300; n++) begin
      int ra;
      int rb;
      ra = int'($urandom() % (1 << W));
      rb = int'($urandom() % (1 << W));
      apply(ra, rb);
      check("R7 random", prod, ref_prod(ra, rb));
    end
    // R7: large then zero, no trace of the previous pair
    apply(15, 15);
    apply(0, 9);
    check("R7 no memory", prod, '0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule